// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Window

This block compares two divided pulse trains, one from the reference divider and one from the main (VCO) divider. Each input is a strobe one system clock wide. The block drives a coarse error output made of an up strobe, a down strobe and an output enable for a three-state error pin. It also drives an active-low lock flag, which has its own open-drain style enable.

Whichever strobe arrives first starts a comparison. The block counts system clock cycles until the other strobe arrives. When the measured error is strictly smaller than the programmed window, lock is declared and the coarse output goes high impedance, so a finer detector further along the loop can take over. While locked, the lock is dropped in the same cycle that an open comparison's count reaches the window.

The sequencer has four states:
- `ST_IDLE`: no edge is pending.
- `ST_REF_LEAD`: the reference strobe came first.
- `ST_VCO_LEAD`: the VCO strobe came first.
- `ST_CLEAR`: both flags are being cleared for one cycle.

The transitions are:
- `T_REF_FIRST`: from IDLE to REF_LEAD on a reference strobe alone.
- `T_VCO_FIRST`: from IDLE to VCO_LEAD on a VCO strobe alone.
- `T_COINCIDE`: from IDLE to CLEAR when both strobes arrive in one cycle.
- `T_VCO_CLOSE`: from REF_LEAD to CLEAR.
- `T_REF_CLOSE`: from VCO_LEAD to CLEAR.
- `T_RELEASE`: from CLEAR to IDLE.
- `T_WAIT`: a leading state holds its state.

Top module: `pfd_lockwin`

## Requirements
- R1: After reset, up, down and err_oe are 0, lock_oe is 0 and lock_n is 1.
- R2: A reference strobe arriving alone while idle and unlocked makes down and err_oe 1 from the next cycle, and they stay 1 until the clock edge that samples a VCO strobe.
- R3: A VCO strobe arriving alone while idle and unlocked makes up and err_oe 1 from the next cycle, and they stay 1 until the clock edge that samples a reference strobe.
- R4: The strobe that closes a comparison is followed by exactly one clear cycle with up and down at 0. Both strobes are ignored in that cycle, and the block is idle afterwards.
- R5: Further strobes on the leading input during an open comparison are ignored. The lead direction and the cycle count from the first strobe are kept.
- R6: The measured error is the number of clock edges from the first strobe to the second, and 0 when both arrive in the same cycle. At the closing edge, lock is set when error < win_cycles and cleared otherwise.
- R7: While locked, up, down and err_oe are 0, lock_oe is 1 and lock_n is 0.
- R8: A win_cycles value of 0 never produces lock.
- R9: While locked, an open comparison whose count (1 in the first cycle after the first strobe, rising by one each cycle) is at least win_cycles clears lock at that edge, so the coarse output resumes before the second strobe arrives.
- R10: The error count saturates at 255 instead of wrapping, so a very long lead never produces lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_evt | input | 1 | Reference divider output strobe, one cycle wide |
| vco_evt | input | 1 | Main divider output strobe, one cycle wide |
| win_cycles | input | 8 | Lock window in clock cycles; 0 disables lock |
| up | output | 1 | Positive coarse pulse: VCO side leads |
| down | output | 1 | Negative coarse pulse: reference side leads |
| err_oe | output | 1 | Drive enable of the three-state coarse error pin |
| lock_n | output | 1 | Active-low lock flag |
| lock_oe | output | 1 | Open-drain pull-down enable for the lock flag |

## Verification
The coarse outputs are decoded from the sequencer state, so a strobe sampled at a rising edge shows up on up, down or err_oe right after that edge. The lock flag is a register that changes at the edge that closes a comparison, or at the edge where an open count reaches the window, and it is also visible right after that edge. The bench applies each stimulus at a falling edge, and a reference model advances at the same rising edge as the design. The bench then compares all five outputs at the next falling edge, which is exactly one edge after the stimulus.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REF_LEAD = 2'd1,
        ST_VCO_LEAD = 2'd2,
        ST_CLEAR    = 2'd3
    } pfd_state_t;
endpackage

// File: rtl/pfd_seq.sv
`timescale 1ns/1ps
module pfd_seq
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_evt,
    input  logic       vco_evt,
    output pfd_state_t state,
    output logic       start,
    output logic       close,
    output logic       coincide
);
    pfd_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        start    = 1'b0;
        close    = 1'b0;
        coincide = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_evt && vco_evt) begin          // T_COINCIDE
                    state_nx = ST_CLEAR;
                    close    = 1'b1;
                    coincide = 1'b1;
                end else if (ref_evt) begin            // T_REF_FIRST
                    state_nx = ST_REF_LEAD;
                    start    = 1'b1;
                end else if (vco_evt) begin            // T_VCO_FIRST
                    state_nx = ST_VCO_LEAD;
                    start    = 1'b1;
                end
            end
            ST_REF_LEAD: begin
                if (vco_evt) begin                     // T_VCO_CLOSE
                    state_nx = ST_CLEAR;
                    close    = 1'b1;
                end
            end
            ST_VCO_LEAD: begin
                if (ref_evt) begin                     // T_REF_CLOSE
                    state_nx = ST_CLEAR;
                    close    = 1'b1;
                end
            end
            ST_CLEAR: state_nx = ST_IDLE;              // T_RELEASE
        endcase
    end

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CLEAR |=> state == ST_IDLE); // R4
    AST_REF_LEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF_LEAD && !vco_evt) |=> state == ST_REF_LEAD); // R5
    AST_VCO_LEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VCO_LEAD && !ref_evt) |=> state == ST_VCO_LEAD); // R5
endmodule

// File: rtl/pfd_meter.sv
`timescale 1ns/1ps
module pfd_meter
    import pfd_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pfd_state_t       state,
    input  logic             start,
    input  logic             close,
    input  logic             coincide,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             locked
);
    localparam int CNT_W = WIN_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] measured;
    logic             leading;

    assign leading  = (state == ST_REF_LEAD) || (state == ST_VCO_LEAD);
    assign measured = coincide ? '0 : cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(1);
        end else if (leading && !close && cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (close) begin
            locked <= (measured < win_cycles);
        end else if (leading && cnt >= win_cycles) begin
            locked <= 1'b0;
        end
    end

    AST_START_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == CNT_W'(1)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (leading && !close && !start && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R10
    AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (close && win_cycles == '0) |=> !locked); // R8
    AST_EARLY_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (leading && !close && cnt >= win_cycles) |=> !locked); // R9
endmodule

// File: rtl/pfd_lockwin.sv
`timescale 1ns/1ps
module pfd_lockwin
    import pfd_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_evt,
    input  logic             vco_evt,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             up,
    output logic             down,
    output logic             err_oe,
    output logic             lock_n,
    output logic             lock_oe
);
    pfd_state_t state;
    logic       start;
    logic       close;
    logic       coincide;
    logic       locked;

    pfd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_evt  (ref_evt),
        .vco_evt  (vco_evt),
        .state    (state),
        .start    (start),
        .close    (close),
        .coincide (coincide)
    );

    pfd_meter #(.WIN_W(WIN_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .start      (start),
        .close      (close),
        .coincide   (coincide),
        .win_cycles (win_cycles),
        .locked     (locked)
    );

    always_comb begin
        up      = 1'b0;
        down    = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_REF_LEAD: down = !locked;
            ST_VCO_LEAD: up   = !locked;
            ST_CLEAR:    ;
        endcase
        err_oe  = up || down;
        lock_oe = locked;
        lock_n  = !locked;
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down)); // R7
    AST_DOWN_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_evt && !vco_evt && !locked) |=> down); // R2
    AST_UP_AFTER_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && vco_evt && !ref_evt && !locked) |=> up); // R3
endmodule

// File: tb/pfd_lockwin_test.sv
`timescale 1ns/1ps
module pfd_lockwin_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_evt = 1'b0;
    logic       vco_evt = 1'b0;
    logic [7:0] win_cycles = 8'd0;
    logic       up, down, err_oe, lock_n, lock_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pfd_lockwin uut (
        .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .vco_evt(vco_evt),
        .win_cycles(win_cycles), .up(up), .down(down), .err_oe(err_oe),
        .lock_n(lock_n), .lock_oe(lock_oe)
    );

    // reference model: 0 idle, 1 reference leads, 2 vco leads, 3 clear
    int m_st = 0;
    int m_cnt = 0;
    bit m_lock = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_lock = 1'b0;
        end else begin
            bit cl, co, st, ld;
            int meas, nst;
            cl = 0; co = 0; st = 0; nst = m_st;
            ld = (m_st == 1 || m_st == 2);
            case (m_st)
                0: if (ref_evt && vco_evt) begin cl = 1; co = 1; nst = 3; end
                   else if (ref_evt) begin st = 1; nst = 1; end
                   else if (vco_evt) begin st = 1; nst = 2; end
                1: if (vco_evt) begin cl = 1; nst = 3; end
                2: if (ref_evt) begin cl = 1; nst = 3; end
                default: nst = 0;
            endcase
            meas = co ? 0 : m_cnt;
            if (cl) m_lock = (meas < int'(win_cycles));
            else if (ld && m_cnt >= int'(win_cycles)) m_lock = 1'b0;
            if (st) m_cnt = 1;
            else if (ld && !cl && m_cnt < 255) m_cnt = m_cnt + 1;
            m_st = nst;
        end
    end

    function automatic logic [4:0] expect_outs();
        logic eu, ed;
        eu = (m_st == 2) && !m_lock;
        ed = (m_st == 1) && !m_lock;
        return {eu, ed, eu | ed, !m_lock, m_lock};
    endfunction

    task automatic check(input string tag);
        logic [4:0] act, exp;
        act = {up, down, err_oe, lock_n, lock_oe};
        exp = expect_outs();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s up,down,err_oe,lock_n,lock_oe actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input string tag);
        ref_evt = r; vco_evt = v;
        @(posedge clk); #1;
        ref_evt = 1'b0; vco_evt = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd7331));
        @(negedge clk);
        check("R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 with R5: reference leads, extra reference strobe ignored
        win_cycles = 8'd0;
        step(1, 0, "R2");
        step(0, 0, "R2");
        step(1, 0, "R5");
        step(0, 0, "R5");
        step(0, 1, "R4");      // closes; clear cycle
        step(0, 0, "R4");      // idle again
        // R3: vco leads
        step(0, 1, "R3");
        step(0, 0, "R3");
        step(1, 0, "R4");
        // R4: strobes during clear are ignored
        step(1, 0, "R4");
        step(0, 0, "R4");
        // R8: window 0, coincident strobes (error 0) do not lock
        step(1, 1, "R8");
        step(0, 0, "R8");
        // R6/R7: error 3 with window 5 locks
        win_cycles = 8'd5;
        step(1, 0, "R6");
        step(0, 0, "R6");
        step(0, 0, "R6");
        step(0, 1, "R6");
        step(0, 0, "R7");
        step(0, 1, "R7");
        step(0, 0, "R7");
        step(1, 0, "R7");
        step(0, 0, "R7");
        // R9: locked, window 3, long lead drops lock early
        win_cycles = 8'd3;
        step(1, 0, "R9");
        for (int i = 0; i < 5; i++) step(0, 0, "R9");
        step(0, 1, "R9");
        step(0, 0, "R9");
        // R6: coincident strobes with window 1 lock
        win_cycles = 8'd1;
        step(1, 1, "R6");
        step(0, 0, "R7");
        // R8: window 0 while locked, coincident close unlocks
        win_cycles = 8'd0;
        step(1, 1, "R8");
        step(0, 0, "R8");
        // R10: very long lead with maximum window never locks
        win_cycles = 8'd255;
        step(0, 1, "R10");
        for (int i = 0; i < 300; i++) step(0, 0, "R10");
        step(1, 0, "R10");
        step(0, 0, "R10");

        // constrained random strobes and windows
        for (int i = 0; i < 6000; i++) begin
            logic r, v;
            if (i % 250 == 0) win_cycles = 8'($urandom % 14);
            r = ($urandom % 7) == 0;
            v = ($urandom % 7) == 0;
            step(r, v, "R6");
        end
        finish_run();
    end
endmodule